// File: doc/BRIEF.md
# Timed Manchester Uplink Transmitter

This block sends a tag's reply to a reader by switching the load on the antenna coil. A start request brings in three things: a frame of up to `MAX_BYTES` bytes, the number of valid bits in it, and a reply delay counted in carrier periods. The block then waits for a window measured from the reader's most recent field edge. The window is the delay minus a fixed compensation for the reader gap. When the window has passed, the block sends a fixed run of start bits and then the data bits, all Manchester coded.

Timing comes from a one-cycle strobe, `carrier_tick`, that pulses once per carrier period. Each bit lasts a fixed number of periods. The coil level inverts at a fixed point inside each bit, and the bit timer starts again at every bit boundary. Reader edges reset the delay reference only while no bits are being sent. When the last bit ends, the coil is released, `busy` drops and `done` pulses for one cycle.

Top module: `timed_manchester_tx`

## Requirements
- R1: While reset is applied, and right after it is released, `coil_load`, `busy` and `done` are all 0.
- R2: Transmission begins once the number of `carrier_tick` pulses since the last `reader_edge` reaches `reply_delay` − 8, or at once if `reply_delay` ≤ 8. A `reader_edge` that arrives during the wait restarts the count. With the defaults, a delay of 208 starts the reply 200 periods after the edge.
- R3: Every reply begins with five 1 bits, before any data bit.
- R4: A 1 bit loads the coil (`coil_load`=1) for the first 15 carrier periods of the bit and unloads it for the next 16. A 0 bit does the opposite.
- R5: Every bit lasts exactly 31 carrier periods, and the bit timer restarts at each bit boundary. A reply of n bits therefore spans 31·n periods from the first load to `done`.
- R6: Data bit d (counting from 0) is taken from `frame_bits[8*(d/8) + 7 − d%8]`. Byte k occupies bits [8k+7:8k], the bytes are sent in increasing k, and each byte goes most significant bit first.
- R7: `coil_load` is 0 while idle, during the delay wait, and from the cycle in which `done` is high onward.
- R8: A `reader_edge` that arrives while bits are being sent does not change the bit timing. The reply still spans 31·n periods.
- R9: `busy` is 1 from the cycle after an accepted start until the final bit ends. `done` is high for exactly one cycle per reply, in the cycle in which `busy` first reads 0 again.
- R10: A `tx_start` that arrives while `busy` is 1 is ignored. The reply in progress keeps its data, length and timing.
- R11: A `bit_len` greater than 8·`MAX_BYTES` is reduced to 8·`MAX_BYTES`. A `bit_len` of 0 sends only the five start bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| carrier_tick | input | 1 | One-cycle strobe, once per carrier period |
| reader_edge | input | 1 | One-cycle strobe on a rising edge of the reader field |
| tx_start | input | 1 | Request to send the presented frame |
| frame_bits | input | 8·MAX_BYTES | Frame data; byte k occupies bits [8k+7:8k] |
| bit_len | input | clog2(8·MAX_BYTES+1) | Number of data bits to send |
| reply_delay | input | DLY_W | Reply delay in carrier periods |
| coil_load | output | 1 | 1 = coil loaded (modulating), 0 = unloaded |
| busy | output | 1 | A reply is waiting or being sent |
| done | output | 1 | One-cycle pulse when a reply completes |

## Verification
Some properties are checked by assertions on every cycle. The bit timer stays below 31 and clears at each bit end. The bit timer moves only on carrier strobes, so reader edges cannot shift it. A saturating gap counter clears on an edge. Sending never starts before the gap is reached. The first half period of a reply is loaded. `done` is a single-cycle pulse with the coil released. A start while busy leaves the latched frame untouched.

Other properties can only be shown by the bench's scenarios, with a cycle-by-cycle model that holds a queue of bits. These are:
- the absolute delay measured from the last reader edge, including a restart during the wait and a delay below the compensation;
- the exact Manchester waveform for each bit and the MSB-first byte order;
- the total length of a reply when edges arrive during it;
- length clamping and the empty data case.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WAIT = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;

  // Target count for the gap wait: the delay less the compensation, floored at zero.
  function automatic int gap_target(int dly, int comp);
    return (dly > comp) ? (dly - comp) : 0;
  endfunction

  // Flat position of data bit d: bytes in ascending order, MSB first inside each byte.
  function automatic int frame_pos(int d);
    return (d / 8) * 8 + (7 - (d % 8));
  endfunction

  // Coil level for a bit value at a given period inside the bit.
  function automatic logic manchester_level(logic b, int tmr, int half);
    return (tmr < half) ? b : ~b;
  endfunction

  // Number of data bits actually sent for a requested length.
  function automatic int clamp_len(int len, int cap);
    return (len > cap) ? cap : len;
  endfunction

endpackage

// File: rtl/mtx_gap_timer.sv
module mtx_gap_timer #(
  parameter int CNT_W = 10,
  parameter int TGT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [TGT_W-1:0] target,
  output logic             reached
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (clr)                        cnt_q <= '0;
    else if (tick && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + 1'b1;
  end

  assign reached = (cnt_q >= CNT_W'(target));

  AST_GAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R2
  AST_GAP_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == CNT_MAX) && !clr) |=> (cnt_q == CNT_MAX)); // R2

endmodule

// File: rtl/mtx_bit_clock.sv
module mtx_bit_clock #(
  parameter int BIT_PER = 31,
  parameter int TMR_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  output logic [TMR_W-1:0] tmr,
  output logic             bit_end
);
  assign bit_end = run && tick && (tmr == TMR_W'(BIT_PER - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tmr <= '0;
    else if (!run || bit_end)  tmr <= '0;
    else if (tick)             tmr <= tmr + 1'b1;
  end

  AST_TMR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tmr) < BIT_PER); // R5
  AST_BIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> (tmr == '0)); // R5
  AST_TMR_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(tmr)); // R8

endmodule

// File: rtl/mtx_bit_picker.sv
module mtx_bit_picker
  import mtx_pkg::*;
#(
  parameter int MAX_BITS = 64,
  parameter int SOF_BITS = 5,
  parameter int IDX_W    = 7
) (
  input  logic [MAX_BITS-1:0] frame,
  input  logic [IDX_W-1:0]    idx,
  output logic                bit_val
);
  localparam int POS_W = $clog2(MAX_BITS);

  logic data_bit;

  assign data_bit = frame[POS_W'(frame_pos(int'(idx) - SOF_BITS))];

  generate
    if (SOF_BITS > 0) begin : g_sof
      assign bit_val = (int'(idx) < SOF_BITS) ? 1'b1 : data_bit;
    end else begin : g_nosof
      assign bit_val = data_bit;
    end
  endgenerate

endmodule

// File: rtl/timed_manchester_tx.sv
module timed_manchester_tx
  import mtx_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int DLY_W     = 9,
  parameter int SOF_BITS  = 5,
  parameter int HALF_PER  = 15,
  parameter int BIT_PER   = 31,
  parameter int GAP_COMP  = 8,
  localparam int MAX_BITS = MAX_BYTES * 8,
  localparam int LEN_W    = $clog2(MAX_BITS + 1),
  localparam int IDX_W    = $clog2(SOF_BITS + MAX_BITS + 1),
  localparam int TMR_W    = $clog2(BIT_PER + 1),
  localparam int GAP_W    = DLY_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                carrier_tick,
  input  logic                reader_edge,
  input  logic                tx_start,
  input  logic [MAX_BITS-1:0] frame_bits,
  input  logic [LEN_W-1:0]    bit_len,
  input  logic [DLY_W-1:0]    reply_delay,
  output logic                coil_load,
  output logic                busy,
  output logic                done
);

  tx_state_e           state_q;
  logic [MAX_BITS-1:0] frame_q;
  logic [IDX_W-1:0]    idx_q;
  logic [IDX_W-1:0]    last_q;
  logic [DLY_W-1:0]    tgt_q;
  logic                done_q;

  // Named internal events
  logic             sending;
  logic             gap_clr;
  logic             gap_reached;
  logic             bit_end;
  logic [TMR_W-1:0] bit_tmr;
  logic             cur_bit;
  logic             accept;
  logic             last_bit_end;

  assign sending      = (state_q == TX_SEND);
  assign gap_clr      = reader_edge && !sending;
  assign accept       = tx_start && (state_q == TX_IDLE);
  assign last_bit_end = sending && bit_end && (idx_q == last_q);

  mtx_gap_timer #(
    .CNT_W (GAP_W),
    .TGT_W (DLY_W)
  ) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (carrier_tick),
    .clr     (gap_clr),
    .target  (tgt_q),
    .reached (gap_reached)
  );

  mtx_bit_clock #(
    .BIT_PER (BIT_PER),
    .TMR_W   (TMR_W)
  ) u_bclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (sending),
    .tick    (carrier_tick),
    .tmr     (bit_tmr),
    .bit_end (bit_end)
  );

  mtx_bit_picker #(
    .MAX_BITS (MAX_BITS),
    .SOF_BITS (SOF_BITS),
    .IDX_W    (IDX_W)
  ) u_pick (
    .frame   (frame_q),
    .idx     (idx_q),
    .bit_val (cur_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      frame_q <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      tgt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        TX_IDLE: begin
          idx_q <= '0;
          if (accept) begin
            frame_q <= frame_bits;
            last_q  <= IDX_W'(SOF_BITS + clamp_len(int'(bit_len), MAX_BITS) - 1);
            tgt_q   <= DLY_W'(gap_target(int'(reply_delay), GAP_COMP));
            state_q <= TX_WAIT;
          end
        end
        TX_WAIT: begin
          if (gap_reached) begin
            idx_q   <= '0;
            state_q <= TX_SEND;
          end
        end
        TX_SEND: begin
          if (last_bit_end) begin
            state_q <= TX_IDLE;
            done_q  <= 1'b1;
          end else if (bit_end) begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign coil_load = sending && manchester_level(cur_bit, int'(bit_tmr), HALF_PER);
  assign busy      = (state_q != TX_IDLE);
  assign done      = done_q;

  AST_SEND_NEEDS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == TX_WAIT) && !gap_reached) |=> !sending); // R2
  AST_REPLY_OPENS_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sending) |-> coil_load); // R3
  AST_RELEASED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !coil_load); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_start) |=> ($stable(frame_q) && $stable(last_q))); // R10

endmodule

// File: tb/timed_manchester_tx_tb.sv
module timed_manchester_tx_tb;
  localparam int MAX_BITS = 64;
  localparam int SOF      = 5;
  localparam int HALF     = 15;
  localparam int BITP     = 31;
  localparam int COMP     = 8;
  localparam int GAPMAX   = 1023;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        carrier_tick = 1'b0;
  logic        reader_edge = 1'b0;
  logic        tx_start = 1'b0;
  logic [63:0] frame_bits = '0;
  logic [6:0]  bit_len = '0;
  logic [8:0]  reply_delay = '0;
  logic        coil_load, busy, done;

  always #2 clk = ~clk;

  timed_manchester_tx u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .carrier_tick (carrier_tick),
    .reader_edge  (reader_edge),
    .tx_start     (tx_start),
    .frame_bits   (frame_bits),
    .bit_len      (bit_len),
    .reply_delay  (reply_delay),
    .coil_load    (coil_load),
    .busy         (busy),
    .done         (done)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Carrier strobe: one cycle high out of every four
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      carrier_tick = 1'b1;
      @(negedge clk);
      carrier_tick = 1'b0;
    end
  end

  // Behavioural reference: a queue of bits to send and plain integer counters
  int m_state = 0;
  int m_gap   = 0;
  int m_tmr   = 0;
  int m_sent  = 0;
  int m_tgt   = 0;
  bit m_done  = 1'b0;
  bit m_q[$];

  always @(posedge clk or negedge rst_n) begin
    int gap_old;
    if (!rst_n) begin
      m_state = 0; m_gap = 0; m_tmr = 0; m_sent = 0; m_done = 1'b0;
      m_q.delete();
    end else begin
      gap_old = m_gap;
      m_done  = 1'b0;
      if (reader_edge && m_state != 2) m_gap = 0;
      else if (carrier_tick && m_gap < GAPMAX) m_gap++;
      if (m_state == 0) begin
        if (tx_start) begin
          int n;
          n = (int'(bit_len) > MAX_BITS) ? MAX_BITS : int'(bit_len);
          m_q.delete();
          repeat (SOF) m_q.push_back(1'b1);
          for (int d = 0; d < n; d++) m_q.push_back(frame_bits[(d / 8) * 8 + 7 - (d % 8)]);
          m_tgt   = (int'(reply_delay) > COMP) ? int'(reply_delay) - COMP : 0;
          m_state = 1;
        end
      end else if (m_state == 1) begin
        if (gap_old >= m_tgt) begin
          m_state = 2; m_tmr = 0; m_sent = 0;
        end
      end else begin
        if (carrier_tick) begin
          m_tmr++;
          if (m_tmr == BITP) begin
            m_tmr = 0;
            void'(m_q.pop_front());
            m_sent++;
            if (m_q.size() == 0) begin
              m_state = 0;
              m_done  = 1'b1;
            end
          end
        end
      end
    end
  end

  // Compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit    m_coil;
      string tag;
      m_coil = (m_state == 2) && ((m_tmr < HALF) ? m_q[0] : !m_q[0]);
      tag    = (m_state != 2) ? "R7" : ((m_sent < SOF) ? "R3" : "R4 R6");
      check(coil_load === m_coil, tag, int'(coil_load), int'(m_coil));
      check(busy === (m_state != 0), "R9 R10", int'(busy), int'(m_state != 0));
      check(done === m_done, "R9", int'(done), int'(m_done));
    end
  end

  // Measurement monitors
  int gap_b = 0;
  int tick_total = 0;
  int gap_at_rise = -1;
  int tick_at_rise = 0;
  int last_dur = -1;
  int done_cnt = 0;
  bit sending_f = 1'b0;
  logic coil_prev = 1'b0;

  always @(posedge clk) begin
    if (reader_edge) gap_b <= 0;
    else if (carrier_tick) gap_b <= gap_b + 1;
    if (carrier_tick) tick_total <= tick_total + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (coil_load && !coil_prev && !sending_f && busy) begin
        sending_f    = 1'b1;
        gap_at_rise  = gap_b;
        tick_at_rise = tick_total;
      end
      if (done) begin
        done_cnt++;
        if (sending_f) begin
          sending_f = 1'b0;
          last_dur  = tick_total - tick_at_rise;
        end
      end
      coil_prev = coil_load;
    end
  end

  task automatic pulse_edge();
    reader_edge = 1'b1;
    @(negedge clk);
    reader_edge = 1'b0;
  endtask

  task automatic send(input logic [63:0] f, input int len, input int dly);
    frame_bits  = f;
    bit_len     = 7'(len);
    reply_delay = 9'(dly);
    tx_start    = 1'b1;
    @(negedge clk);
    tx_start    = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(coil_load === 1'b0, "R1", int'(coil_load), 0);
    check(busy === 1'b0, "R1", int'(busy), 0);
    check(done === 1'b0, "R1", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(coil_load === 1'b0 && busy === 1'b0 && done === 1'b0, "R1",
          int'({coil_load, busy, done}), 0);
    repeat (10) @(negedge clk);

    // One byte, nominal delay
    pulse_edge();
    send(64'h0000_0000_0000_00A5, 8, 208);
    wait_done();
    check(gap_at_rise == 200, "R2", gap_at_rise, 200);
    check(last_dur == BITP * 13, "R5", last_dur, BITP * 13);
    check(done_cnt == 1, "R9", done_cnt, 1);

    // Edge restarts the wait; starts while busy are ignored
    repeat (20) @(negedge clk);
    pulse_edge();
    send(64'h0000_0000_0000_C33C, 16, 212);
    send(64'hFFFF_FFFF_FFFF_FFFF, 3, 10);
    repeat (200) @(negedge clk);
    pulse_edge();
    while (!coil_load) @(negedge clk);
    send(64'h0000_0000_0000_0000, 3, 10);
    wait_done();
    check(gap_at_rise == 204, "R2", gap_at_rise, 204);
    check(last_dur == BITP * 21, "R10", last_dur, BITP * 21);
    check(done_cnt == 2, "R10", done_cnt, 2);

    // Delay below the compensation: send right after the wait state
    repeat (20) @(negedge clk);
    frame_bits  = 64'h0000_0000_0000_00FF;
    bit_len     = 7'd8;
    reply_delay = 9'd5;
    tx_start    = 1'b1;
    @(negedge clk);
    tx_start    = 1'b0;
    check(coil_load === 1'b0 && busy === 1'b1, "R2", int'({busy, coil_load}), 2);
    @(negedge clk);
    check(coil_load === 1'b1, "R2", int'(coil_load), 1);
    wait_done();
    check(last_dur == BITP * 13, "R5", last_dur, BITP * 13);

    // Reader edges during transmission do not disturb timing
    repeat (20) @(negedge clk);
    pulse_edge();
    send(64'h0000_0000_0096_5AE1, 24, 204);
    while (!coil_load) @(negedge clk);
    repeat (20) begin
      repeat (37) @(negedge clk);
      pulse_edge();
    end
    wait_done();
    check(gap_at_rise == 196, "R2", gap_at_rise, 196);
    check(last_dur == BITP * 29, "R8", last_dur, BITP * 29);

    // Empty data: start bits only
    repeat (20) @(negedge clk);
    pulse_edge();
    send(64'h0123_4567_89AB_CDEF, 0, 208);
    wait_done();
    check(last_dur == BITP * SOF, "R11", last_dur, BITP * SOF);

    // Over-long length is clamped to the frame capacity
    repeat (20) @(negedge clk);
    pulse_edge();
    send(64'hDEAD_BEEF_0123_A55A, 100, 208);
    wait_done();
    check(last_dur == BITP * (SOF + MAX_BITS), "R11", last_dur, BITP * (SOF + MAX_BITS));
    check(done_cnt == 6, "R9", done_cnt, 6);
    check(coil_load === 1'b0 && busy === 1'b0, "R7", int'({busy, coil_load}), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R9 actual %0d expected %0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule